// File: doc/BRIEF.md
# Programmable-Polarity SRAM Select Pipeline

This block is the control front end of a pipelined synchronous SRAM, with a small storage array attached so that reads and writes can be followed end to end. On each rising clock edge it samples three chip enables, a word address, an active-low write strobe and write data. The first enable is active low. The other two enables each have a polarity set by a static strap pin. A selected write stores the data. A selected read returns the stored word through a fixed-length output pipeline, together with an output-enable flag for the data bus.

The block also drives a pair of echo clocks, along with an enable that stands in for their high-impedance state. The echo clock enable follows only the two strap-controlled enables, and it goes through the same pipeline as the read data. A deselect through those two enables therefore stops the echo clocks in the cycle the data bus goes idle. A deselect through the first enable alone leaves the echo clocks running.

Four instances, strapped with the codes 00, 01, 10 and 11 and with their two programmable enables wired to the two top address bits, form a memory four times as deep without any external decode.

Top module: `sram_select_pipe`

## Requirements
- R1: The enable `en2_i` counts as asserted when its level equals `pol2_i` (strap high means active high, strap low means active low). `en3_i` follows `pol3_i` in the same way.
- R2: The device is selected only when `en1_ni` is low and both `en2_i` and `en3_i` are asserted under their strap polarity.
- R3: A write (`we_ni` low) sampled while the device is selected stores `wdata_i` at `addr_i`. A write sampled while the device is deselected leaves the array unchanged, which a later read of that address shows.
- R4: A selected read (`we_ni` high) sampled at edge k sets `dq_oe_o` high and drives the stored word on `rdata_o` from edge k+RD_LAT-1 until the next edge. In all other cycles `dq_oe_o` is low and `rdata_o` is zero.
- R5: `cq_oe_o` is high from edge k+RD_LAT-1 exactly when `en2_i` and `en3_i` were both asserted at edge k, with the same latency as `dq_oe_o`.
- R6: A deselect caused only by `en1_ni` being high drops `dq_oe_o` but leaves `cq_oe_o` high.
- R7: `cq_o` equals `clk_i` and `cq_no` equals the inverse of `clk_i` while `cq_oe_o` is high. Both are low while `cq_oe_o` is low.
- R8: Four instances strapped with the codes 0 to 3 ({`pol2_i`,`pol3_i`}), with `en2_i` and `en3_i` driven by the upper and lower of two top address bits, behave as one memory: for any address, at most one instance raises `dq_oe_o`, and that is the instance whose code equals the top bits.
- R9: While `rst_ni` is low, `dq_oe_o` and `cq_oe_o` are low and `rdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge samples all inputs |
| rst_ni | input | 1 | Asynchronous active-low reset of the pipeline |
| pol2_i | input | 1 | Static strap: polarity of en2_i (1 = active high) |
| pol3_i | input | 1 | Static strap: polarity of en3_i (1 = active high) |
| en1_ni | input | 1 | Active-low chip enable, does not affect echo clocks |
| en2_i | input | 1 | Strap-polarity chip enable |
| en3_i | input | 1 | Strap-polarity chip enable |
| addr_i | input | ADDR_W | Word address |
| we_ni | input | 1 | Active-low write strobe |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Pipelined read data, zero when not driving |
| dq_oe_o | output | 1 | Data bus drive enable |
| cq_o | output | 1 | Echo clock |
| cq_no | output | 1 | Complementary echo clock |
| cq_oe_o | output | 1 | Echo clock drive enable |

## Verification
Four banks strapped 00 to 11 share every input. Writes and reads are spread over all four values of the top address bits, so each polarity combination is seen both selected and deselected, and any bank that answers an address it does not own is caught. Reads with the first enable held inactive tell apart a deselect that should stop only the data from one that should also stop the echo clocks. Writes made while deselected and then read back show whether a deselect leaks into the array. Alternating back-to-back reads across banks check that the data enable and the echo enable hand over in the same cycle, after the pipeline latency.

// File: rtl/sram_sel_pkg.sv
package sram_sel_pkg;

  typedef struct packed {
    logic rd;
    logic wr;
    logic echo;
  } sel_ctl_t;

  // strap-programmed sense: input is asserted when it equals the strap level
  function automatic logic strap_match(input logic lvl, input logic pol);
    return lvl == pol;
  endfunction

endpackage

// File: rtl/sram_sel_decode.sv
module sram_sel_decode
  import sram_sel_pkg::*;
(
  input  logic     pol2_i,
  input  logic     pol3_i,
  input  logic     en1_ni,
  input  logic     en2_i,
  input  logic     en3_i,
  input  logic     we_ni,
  output sel_ctl_t ctl_o
);

  logic strap_ok;
  logic sel;

  assign strap_ok = strap_match(en2_i, pol2_i) & strap_match(en3_i, pol3_i);
  assign sel      = ~en1_ni & strap_ok;

  assign ctl_o.rd   = sel & we_ni;
  assign ctl_o.wr   = sel & ~we_ni;
  assign ctl_o.echo = strap_ok;

endmodule

// File: rtl/sram_sel_array.sv
module sram_sel_array #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int Depth = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [Depth];

  always_ff @(posedge clk_i) begin
    if (wr_i) mem[addr_i] <= wdata_i;
  end

  // gate to zero so idle cycles never carry stale words
  assign rdata_o = rd_i ? mem[addr_i] : '0;

endmodule

// File: rtl/sram_sel_pipe.sv
module sram_sel_pipe #(
  parameter int W     = 18,
  parameter int DEPTH = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  for (genvar i = 0; i < DEPTH; i++) begin : g_stg
    logic [W-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d_i;
      end
    end else begin : g_body
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= g_stg[i-1].q;
      end
    end
  end

  assign q_o = g_stg[DEPTH-1].q;

endmodule

// File: rtl/sram_select_pipe.sv
module sram_select_pipe
  import sram_sel_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pol2_i,
  input  logic              pol3_i,
  input  logic              en1_ni,
  input  logic              en2_i,
  input  logic              en3_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_ni,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              dq_oe_o,
  output logic              cq_o,
  output logic              cq_no,
  output logic              cq_oe_o
);

  localparam int PipeW = DATA_W + 2;

  sel_ctl_t          ctl;
  logic [DATA_W-1:0] arr_rdata;
  logic [PipeW-1:0]  pipe_d;
  logic [PipeW-1:0]  pipe_q;

  sram_sel_decode u_decode (
    .pol2_i (pol2_i),
    .pol3_i (pol3_i),
    .en1_ni (en1_ni),
    .en2_i  (en2_i),
    .en3_i  (en3_i),
    .we_ni  (we_ni),
    .ctl_o  (ctl)
  );

  sram_sel_array #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_array (
    .clk_i   (clk_i),
    .wr_i    (ctl.wr),
    .rd_i    (ctl.rd),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (arr_rdata)
  );

  // data, its enable and the echo enable share one pipeline so they align
  assign pipe_d = {ctl.rd, ctl.echo, arr_rdata};

  sram_sel_pipe #(
    .W     (PipeW),
    .DEPTH (RD_LAT)
  ) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pipe_d),
    .q_o    (pipe_q)
  );

  assign dq_oe_o = pipe_q[DATA_W+1];
  assign cq_oe_o = pipe_q[DATA_W];
  assign rdata_o = pipe_q[DATA_W-1:0];

  assign cq_o  = clk_i & cq_oe_o;
  assign cq_no = ~clk_i & cq_oe_o;

endmodule

// File: rtl/sram_select_pipe_chk.sv
module sram_select_pipe_chk #(
  parameter int DATA_W = 16,
  parameter int RD_LAT = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pol2_i,
  input logic              pol3_i,
  input logic              en1_ni,
  input logic              en2_i,
  input logic              en3_i,
  input logic              we_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              dq_oe_o,
  input logic              cq_o,
  input logic              cq_no,
  input logic              cq_oe_o
);

  logic [RD_LAT-1:0] sh_rd;
  logic [RD_LAT-1:0] sh_echo;
  logic              echo_now;

  assign echo_now = (en2_i == pol2_i) && (en3_i == pol3_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_rd   <= '0;
      sh_echo <= '0;
    end else begin
      sh_rd[0]   <= echo_now && !en1_ni && we_ni;
      sh_echo[0] <= echo_now;
      for (int i = 1; i < RD_LAT; i++) begin
        sh_rd[i]   <= sh_rd[i-1];
        sh_echo[i] <= sh_echo[i-1];
      end
    end
  end

  assert_oe_latency_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o == sh_rd[RD_LAT-1]);

  assert_idle_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dq_oe_o |-> rdata_o == '0);

  assert_echo_latency_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cq_oe_o == sh_echo[RD_LAT-1]);

  // data can only be driven while echo clocks are on
  assert_oe_implies_echo_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> cq_oe_o);

  // sampled just before the falling edge: clock is high
  assert_echo_level_R7: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (cq_o == cq_oe_o) && !cq_no);

endmodule

bind sram_select_pipe sram_select_pipe_chk #(
  .DATA_W (DATA_W),
  .RD_LAT (RD_LAT)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pol2_i  (pol2_i),
  .pol3_i  (pol3_i),
  .en1_ni  (en1_ni),
  .en2_i   (en2_i),
  .en3_i   (en3_i),
  .we_ni   (we_ni),
  .rdata_o (rdata_o),
  .dq_oe_o (dq_oe_o),
  .cq_o    (cq_o),
  .cq_no   (cq_no),
  .cq_oe_o (cq_oe_o)
);

// File: tb/sram_select_pipe_tb.sv
module sram_select_pipe_tb;

  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int LAT = 2;
  localparam int NB  = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic          e1n;
  logic          wen;
  logic [AW+1:0] fa;
  logic [DW-1:0] wd;

  logic [DW-1:0] rd   [NB];
  logic          oe   [NB];
  logic          cq   [NB];
  logic          cqn  [NB];
  logic          cqoe [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    localparam logic [1:0] Code = 2'(b);
    sram_select_pipe #(
      .ADDR_W (AW),
      .DATA_W (DW),
      .RD_LAT (LAT)
    ) u_dut (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .pol2_i  (Code[1]),
      .pol3_i  (Code[0]),
      .en1_ni  (e1n),
      .en2_i   (fa[AW+1]),
      .en3_i   (fa[AW]),
      .addr_i  (fa[AW-1:0]),
      .we_ni   (wen),
      .wdata_i (wd),
      .rdata_o (rd[b]),
      .dq_oe_o (oe[b]),
      .cq_o    (cq[b]),
      .cq_no   (cqn[b]),
      .cq_oe_o (cqoe[b])
    );
  end

  // reference model: one flat memory, bank = top two address bits
  typedef struct packed {
    logic [NB-1:0] oe;
    logic [NB-1:0] cqe;
    logic [DW-1:0] d;
  } exp_t;

  logic [DW-1:0] mdl_mem [NB << AW];
  exp_t q[$];
  exp_t cur;
  exp_t e;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      cur = '0;
    end else begin
      e = '0;
      for (int b = 0; b < NB; b++) begin
        if (int'(fa[AW+1:AW]) == b) begin
          e.cqe[b] = 1'b1;
          if (!e1n && wen) begin
            e.oe[b] = 1'b1;
            e.d     = mdl_mem[fa];
          end
        end
      end
      if (!e1n && !wen) mdl_mem[fa] = wd;
      q.push_back(e);
      if (q.size() > LAT - 1) cur = q.pop_front();
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every cycle, away from the rising edge
  always @(negedge clk) begin
    #1;
    if (!done) begin
      int cnt;
      cnt = 0;
      for (int b = 0; b < NB; b++) begin
        if (!rst_n) begin
          chk(!oe[b] && !cqoe[b] && rd[b] == '0, "R9 reset idle",
              {oe[b], cqoe[b], rd[b]}, 0);
        end else begin
          chk(oe[b] == cur.oe[b], "R2/R4 dq_oe", 32'(oe[b]), 32'(cur.oe[b]));
          chk(rd[b] == (cur.oe[b] ? cur.d : '0), "R3/R4 rdata",
              32'(rd[b]), 32'(cur.oe[b] ? cur.d : '0));
          chk(cqoe[b] == cur.cqe[b], "R1/R5/R6 cq_oe", 32'(cqoe[b]), 32'(cur.cqe[b]));
          chk(!cq[b] && cqn[b] == cur.cqe[b], "R7 echo level",
              {30'd0, cq[b], cqn[b]}, {30'd0, 1'b0, cur.cqe[b]});
        end
        cnt += int'(oe[b]);
      end
      if (rst_n && cur.oe != '0)
        chk(cnt == 1, "R8 one bank drives", 32'(cnt), 1);
    end
  end

  task automatic op(input logic e1, input logic w, input logic [AW+1:0] a,
                    input logic [DW-1:0] d);
    @(negedge clk);
    e1n = e1;
    wen = w;
    fa  = a;
    wd  = d;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nerr++;
    nchk++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b1;
    e1n   = 1'b1;
    wen   = 1'b1;
    fa    = '0;
    wd    = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R3: fill each bank
    for (int b = 0; b < NB; b++)
      for (int i = 0; i < 4; i++)
        op(1'b0, 1'b0, {2'(b), 6'(i * 9 + b)}, 16'hA000 + 16'(b * 256 + i));
    op(1'b1, 1'b1, 8'h00, '0);

    // R4/R8: read back every word, banks interleaved back to back
    for (int i = 0; i < 4; i++)
      for (int b = 0; b < NB; b++)
        op(1'b0, 1'b1, {2'(b), 6'(i * 9 + b)}, '0);

    // R6: first enable inactive, echo stays on the owning bank
    for (int b = 0; b < NB; b++)
      op(1'b1, 1'b1, {2'(b), 6'(b)}, '0);

    // R3: writes while deselected must not land
    op(1'b1, 1'b0, {2'd2, 6'd2}, 16'hDEAD);
    op(1'b1, 1'b0, {2'd1, 6'd10}, 16'hBEEF);
    op(1'b0, 1'b1, {2'd2, 6'd2}, '0);
    op(1'b0, 1'b1, {2'd1, 6'd10}, '0);

    // R5: selected write then repeated read on one bank, then switch banks
    op(1'b0, 1'b0, {2'd3, 6'd63}, 16'h5A5A);
    op(1'b0, 1'b1, {2'd3, 6'd63}, '0);
    op(1'b0, 1'b1, {2'd3, 6'd63}, '0);
    op(1'b0, 1'b1, {2'd0, 6'd0}, '0);
    op(1'b1, 1'b1, {2'd0, 6'd0}, '0);
    op(1'b0, 1'b1, {2'd2, 6'd20}, '0);

    repeat (4) op(1'b1, 1'b1, {2'd1, 6'd0}, '0);
    @(negedge clk);
    #2;
    finish_run();
  end

endmodule